// File: doc/BRIEF.md
# SPI ADC Three-Byte Frame Reader

This block fetches one 20-bit conversion result from an external serial ADC. A single-cycle start request opens a frame; the block then runs three back-to-back 8-bit shifts with no break between them. Each shift clocks a dummy byte out on MOSI and captures one byte from MISO, so the receive side is driven entirely by the transmit side. The block has no chip-select output; a separate timing block drives chip-select and is expected to hold it for the whole time `busy_o` is high.

After the third byte is captured, the block forms the result word from the first 20 bits received and sets a sticky completion interrupt. It then disarms itself. Further start requests are ignored until a rearm strobe arrives while the block is idle, so each frame needs one explicit rearm before the next external trigger.

The serial clock follows SPI mode 0. SCLK idles low and its period is `SCLK_DIV` system clocks.

Top module: `adc_frame_reader`

## Requirements
- R1: A frame starts only when `start_i` is high for a cycle while the block is idle and armed; `busy_o` is high from the next cycle. Without a start request the block stays idle.
- R2: A frame is exactly BYTES×BYTE_W = 24 SCLK periods of SCLK_DIV system clocks each, and `busy_o` stays high without a gap for all 24×SCLK_DIV cycles, across both byte boundaries.
- R3: SCLK idles low. MISO is sampled on the rising SCLK edge and MOSI changes only on the falling edge (SPI mode 0).
- R4: Every transmitted byte is the dummy value 0x00, so MOSI is 0 on every rising SCLK edge.
- R5: `result_o` equals the first 20 bits received, first bit in bit 19 (MSB first, right-justified). The last 4 received bits are dropped. The value holds until the next frame completes.
- R6: `irq_o` rises in the same cycle that `busy_o` falls, after the third byte is captured, and is never high while a frame is running.
- R7: `irq_o` stays high until `irq_clr_i` is pulsed, or until `rearm_i` is pulsed while idle.
- R8: After each frame the block is disarmed, and a start request has no effect until `rearm_i` is pulsed while idle. A `rearm_i` pulse during a frame is ignored.
- R9: A start request during a frame is ignored, and the frame length and result are unaffected.
- R10: After reset, SCLK, MOSI, `result_o`, `busy_o` and `irq_o` are 0, and the block is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle external start request |
| miso_i | input | 1 | Serial data from the ADC |
| irq_clr_i | input | 1 | Clears the completion interrupt |
| rearm_i | input | 1 | Rearms the block for the next start (accepted only when idle) |
| sclk_o | output | 1 | Serial clock, idles low |
| mosi_o | output | 1 | Serial data to the ADC (dummy bytes) |
| result_o | output | RES_W | Right-justified conversion result |
| busy_o | output | 1 | High for the whole three-byte frame |
| irq_o | output | 1 | Sticky completion interrupt |

## Verification
The bench sweeps walking-one and arithmetic 24-bit patterns through a slave model, so a swapped byte slot or a bit taken from the wrong end shows up as a wrong `result_o`. Sampling MISO on the falling edge instead of the rising edge also gives a wrong result. It counts busy cycles and SCLK rising edges in every frame: a design that dropped `busy_o` between bytes, miscounted bytes or bits, or closed the frame early would produce a short count or an early interrupt. On alternate frames it pulses start and rearm during the frame, then tries a start after the frame without a rearm. A design that rearmed while busy or restarted without a rearm would produce extra SCLK edges. The bench also checks that the interrupt stays set until it is cleared by either route.

// File: rtl/afr_pkg.sv
package afr_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_XFER = 1'b1
  } afr_state_e;
endpackage

// File: rtl/afr_half_timer.sv
module afr_half_timer #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = $clog2(HALF + 1);

  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap   = (cnt_q == CW'(HALF - 1));
  assign tick_o = run_i && wrap;

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      cnt_q <= '0;
    end else if (wrap) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  generate
    if (HALF > 1) begin : g_gap
      // R2: half periods last more than one system clock
      p_tick_gap_r2: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/afr_shift_unit.sv
module afr_shift_unit #(
  parameter int                BYTE_W = 8,
  parameter logic [BYTE_W-1:0] DUMMY  = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              run_i,
  input  logic              tick_i,
  input  logic              miso_i,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic              byte_done_o,
  output logic [BYTE_W-1:0] rx_byte_o
);
  localparam int BCW = $clog2(BYTE_W);

  logic              sclk_q;
  logic [BYTE_W-1:0] tx_q;
  logic [BYTE_W-1:0] rx_q;
  logic [BCW-1:0]    bit_q;
  logic              last_bit;

  assign last_bit    = (bit_q == BCW'(BYTE_W - 1));
  assign byte_done_o = run_i && tick_i && sclk_q && last_bit;
  assign sclk_o      = sclk_q;
  assign mosi_o      = tx_q[BYTE_W-1];
  assign rx_byte_o   = rx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= 1'b0;
      tx_q   <= DUMMY;
      rx_q   <= '0;
      bit_q  <= '0;
    end else if (load_i) begin
      sclk_q <= 1'b0;
      tx_q   <= DUMMY;
      bit_q  <= '0;
    end else if (run_i && tick_i) begin
      if (!sclk_q) begin
        sclk_q <= 1'b1;
        rx_q   <= {rx_q[BYTE_W-2:0], miso_i};
      end else begin
        sclk_q <= 1'b0;
        if (last_bit) begin
          bit_q <= '0;
          tx_q  <= DUMMY;
        end else begin
          bit_q <= bit_q + BCW'(1);
          tx_q  <= {tx_q[BYTE_W-2:0], 1'b0};
        end
      end
    end else if (!run_i) begin
      sclk_q <= 1'b0;
    end
  end

  // R3: data out must not move on the rising edge
  p_mosi_hold_rise_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk_q) |-> $stable(mosi_o));

  // R3: a byte only completes on a falling edge
  p_byte_on_fall_r3: assert property (@(posedge clk) disable iff (rst)
    byte_done_o |=> !sclk_o);
endmodule

// File: rtl/afr_frame_ctrl.sv
module afr_frame_ctrl
  import afr_pkg::*;
#(
  parameter int BYTES  = 3,
  parameter int BYTE_W = 8,
  parameter int RES_W  = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              rearm_i,
  input  logic              irq_clr_i,
  input  logic              byte_done_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  output logic              load_o,
  output logic              run_o,
  output logic              busy_o,
  output logic              irq_o,
  output logic [RES_W-1:0]  result_o
);
  localparam int BC  = $clog2(BYTES + 1);
  localparam int TOT = BYTES * BYTE_W;

  afr_state_e        state_q;
  logic              armed_q;
  logic [BC-1:0]     left_q;
  logic [BYTE_W-1:0] mem_q [BYTES-1];
  logic              irq_q;
  logic [RES_W-1:0]  result_q;
  logic [TOT-1:0]    full;
  logic              accept;
  logic              last;

  assign accept   = (state_q == ST_IDLE) && armed_q && start_i;
  assign last     = byte_done_i && (left_q == BC'(1));
  assign load_o   = accept;
  assign run_o    = (state_q == ST_XFER);
  assign busy_o   = (state_q == ST_XFER);
  assign irq_o    = irq_q;
  assign result_o = result_q;

  genvar g;
  generate
    for (g = 0; g < BYTES - 1; g++) begin : g_pack
      assign full[TOT-1-g*BYTE_W -: BYTE_W] = mem_q[g];
    end
  endgenerate
  assign full[BYTE_W-1:0] = rx_byte_i;

  always_ff @(posedge clk) begin
    for (int i = 0; i < BYTES - 1; i++) begin
      if (byte_done_i && left_q == BC'(BYTES - i)) begin
        mem_q[i] <= rx_byte_i;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      armed_q  <= 1'b1;
      left_q   <= BC'(BYTES);
      result_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q <= ST_XFER;
            left_q  <= BC'(BYTES);
          end else if (rearm_i) begin
            armed_q <= 1'b1;
          end
        end
        ST_XFER: begin
          if (last) begin
            state_q  <= ST_IDLE;
            armed_q  <= 1'b0;
            left_q   <= BC'(BYTES);
            result_q <= RES_W'(full >> (TOT - RES_W));
          end else if (byte_done_i) begin
            left_q <= left_q - BC'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
    end else if (last) begin
      irq_q <= 1'b1;
    end else if (irq_clr_i || (rearm_i && state_q == ST_IDLE)) begin
      irq_q <= 1'b0;
    end
  end

  // R2: the frame cannot close before the final byte
  p_hold_frame_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_XFER && !last) |=> (state_q == ST_XFER));

  // R6: interrupt only follows the last captured byte
  p_irq_after_last_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> $past(last));

  // R8: disarmed block ignores start
  p_disarmed_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && !armed_q) |=> (state_q == ST_IDLE));

  // R9: byte counter moves only on completed bytes
  p_count_steady_r9: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_XFER && !byte_done_i) |=> $stable(left_q));
endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader #(
  parameter int                BYTES    = 3,
  parameter int                BYTE_W   = 8,
  parameter int                RES_W    = 20,
  parameter int                SCLK_DIV = 4,
  parameter logic [BYTE_W-1:0] DUMMY    = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             miso_i,
  input  logic             irq_clr_i,
  input  logic             rearm_i,
  output logic             sclk_o,
  output logic             mosi_o,
  output logic [RES_W-1:0] result_o,
  output logic             busy_o,
  output logic             irq_o
);
  localparam int HALF = SCLK_DIV / 2;

  logic              load;
  logic              run;
  logic              tick;
  logic              byte_done;
  logic [BYTE_W-1:0] rx_byte;

  afr_half_timer #(.HALF(HALF)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .run_i  (run),
    .tick_o (tick)
  );

  afr_shift_unit #(.BYTE_W(BYTE_W), .DUMMY(DUMMY)) u_shift (
    .clk         (clk),
    .rst         (rst),
    .load_i      (load),
    .run_i       (run),
    .tick_i      (tick),
    .miso_i      (miso_i),
    .sclk_o      (sclk_o),
    .mosi_o      (mosi_o),
    .byte_done_o (byte_done),
    .rx_byte_o   (rx_byte)
  );

  afr_frame_ctrl #(.BYTES(BYTES), .BYTE_W(BYTE_W), .RES_W(RES_W)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .rearm_i     (rearm_i),
    .irq_clr_i   (irq_clr_i),
    .byte_done_i (byte_done),
    .rx_byte_i   (rx_byte),
    .load_o      (load),
    .run_o       (run),
    .busy_o      (busy_o),
    .irq_o       (irq_o),
    .result_o    (result_o)
  );

  // R3: serial clock is low whenever no frame is running
  p_sclk_idle_r3: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !sclk_o);
endmodule

// File: tb/adc_frame_reader_tb_top.sv
`timescale 1ns/1ps
module adc_frame_reader_tb_top;
  localparam int DIV = 4;
  localparam int TOT = 24;
  localparam int RW  = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, clr = 1'b0, rearm = 1'b0;
  logic miso;
  logic sclk, mosi, busy, irq;
  logic [RW-1:0] result;

  int tests = 0, fails = 0;
  logic [TOT-1:0] pat = '0;
  int nbit = 0, rises = 0, mosi_bad = 0;

  always #2 clk = ~clk;

  adc_frame_reader #(.SCLK_DIV(DIV)) dut_i (
    .clk(clk), .rst(rst), .start_i(start), .miso_i(miso),
    .irq_clr_i(clr), .rearm_i(rearm), .sclk_o(sclk), .mosi_o(mosi),
    .result_o(result), .busy_o(busy), .irq_o(irq)
  );

  // slave model: shifts its next bit out after each falling SCLK edge
  assign miso = (nbit < TOT) ? pat[TOT-1-nbit] : 1'b0;
  always @(negedge sclk) nbit = nbit + 1;
  always @(posedge sclk) begin
    rises = rises + 1;
    if (mosi !== 1'b0) mosi_bad = mosi_bad + 1;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  task automatic run_frame(input logic [TOT-1:0] p, input bit poke, input bit by_rearm);
    int cyc;
    int early;
    pat = p; nbit = 0; rises = 0; mosi_bad = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R1 busy after start", busy, 1);
    cyc = 1; early = 0;
    while (busy && cyc < 2000) begin
      if (irq) early++;
      if (poke && cyc == 30) begin start = 1'b1; rearm = 1'b1; end
      @(negedge clk);
      start = 1'b0; rearm = 1'b0;
      if (busy) cyc++;
    end
    chk(cyc == TOT*DIV, "R2 busy length", cyc, TOT*DIV);
    chk(rises == TOT, "R2 sclk rising edges", rises, TOT);
    chk(early == 0, "R6 irq during frame", early, 0);
    chk(irq == 1'b1, "R6 irq at frame end", irq, 1);
    chk(sclk == 1'b0, "R3 sclk idle low", sclk, 0);
    chk(mosi_bad == 0, "R4 dummy mosi", mosi_bad, 0);
    chk(result == RW'(p >> (TOT-RW)), "R5 result", result, p >> (TOT-RW));
    // disarmed: start must do nothing (R8, also shows rearm during frame was ignored)
    pulse(start);
    repeat (3*DIV) @(negedge clk);
    chk(busy == 1'b0 && rises == TOT, "R8 start ignored while disarmed", rises, TOT);
    chk(irq == 1'b1, "R7 irq held", irq, 1);
    if (by_rearm) begin
      pulse(rearm);
      chk(irq == 1'b0, "R7 rearm clears irq", irq, 0);
    end else begin
      pulse(clr);
      chk(irq == 1'b0, "R7 clear strobe", irq, 0);
      pulse(rearm);
    end
    repeat (DIV) @(negedge clk);
    chk(busy == 1'b0, "R1 no start without request", busy, 0);
    chk(result == RW'(p >> (TOT-RW)), "R5 result held", result, p >> (TOT-RW));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; tests++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(sclk == 1'b0, "R10 reset sclk", sclk, 0);
    chk(mosi == 1'b0, "R10 reset mosi", mosi, 0);
    chk(result == '0, "R10 reset result", result, 0);
    chk(busy == 1'b0, "R10 reset busy", busy, 0);
    chk(irq == 1'b0, "R10 reset irq", irq, 0);
    // first frame needs no rearm: armed out of reset (R10)
    run_frame(24'hFFFFFF, 1'b0, 1'b0);
    run_frame(24'h000000, 1'b1, 1'b1);
    for (int i = 0; i < TOT; i++) begin
      run_frame(24'(1) << i, i[0], (i % 3) == 0);   // R9 via poke on odd frames
    end
    for (int i = 1; i <= 16; i++) begin
      run_frame(24'((i * 32'h9E3779) ^ (i << 17)), i[0], i[1]);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule